// File: doc/BRIEF.md
# Programmable Delayed Output Driver

This block takes one logic input and reproduces it on an external output after a programmable delay. The delay is a time unit multiplied by a step count. The unit is 1 us, 10 us, 100 us or 1 ms, and all four units are derived from the system clock by a free-running prescaler. Every input transition is queued on its own and replayed once its step count of unit ticks has elapsed. A pulse shorter than the delay therefore still appears at the output.

A polarity select maps the delayed logic level to the active (ON) or inactive (OFF) output state. The output is presented as a single-ended pin. When the block is built in its differential variant, it also drives a complementary leg pair. A fault input overrides the normal path with a configured safe behaviour. The configuration is captured only while the enable input is low. Dropping the enable turns the output OFF and discards every pending transition.

Top module: `dly_out_driver`

## Requirements
- R1: With step count S ≥ 1 and unit code u (0 = 1 us, 1 = 10 us, 2 = 100 us, 3 = 1 ms), one unit U lasts CLKS_PER_US·10^u clocks. An input transition reaches the output no earlier than (S−1)·U clocks and no later than S·U + 4 clocks after it is applied. A 20 us delay set either as 20 × 1 us or as 2 × 10 us stays within one unit of 20 us.
- R2: A step count of 0 bypasses the delay: an input change driven before clock edge k shows on the output after edge k+2.
- R3: With invert = 0 a delayed high level gives ON (out_se = 1) and a low level gives OFF. With invert = 1 the mapping is reversed.
- R4: out_p equals out_se. In the differential variant out_n is the complement of out_p on every cycle, including reset and fault entry and exit.
- R5: Each transition is delayed independently. A pulse shorter than the delay comes out with its width preserved to within one unit.
- R6: Up to 4 transitions can be pending. A further transition while 4 are pending is dropped and sets the sticky overflow flag. Deasserting enable clears the flag.
- R7: While fault is high and the block is enabled, the output follows fault_mode and ignores invert: 0 holds the last output value, 1 forces ON, 2 and 3 force OFF. On release the output resumes from the current delayed level.
- R8: unit_sel, step_cnt, invert and fault_mode are captured only while en is low. Changes made while en is high have no effect.
- R9: With en low the output is OFF from the next clock edge on. Transitions pending when en falls are discarded and never reach the output.
- R10: After reset out_se and out_p are 0, out_n is 1 (differential variant) and overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Output enable; configuration loads while low |
| din | input | 1 | Logic input to be delayed |
| unit_sel | input | 2 | Time unit code: 1 us, 10 us, 100 us, 1 ms |
| step_cnt | input | STEP_W | Number of units in the delay |
| invert | input | 1 | Polarity select: 1 reverses ON/OFF |
| fault | input | 1 | Fault override request |
| fault_mode | input | 2 | Fault behaviour: hold, ON, OFF, OFF |
| out_se | output | 1 | Single-ended output, 1 = ON |
| out_p | output | 1 | Positive differential leg |
| out_n | output | 1 | Negative differential leg (0 in single-ended variant) |
| overflow | output | 1 | Sticky flag for a dropped transition |

## Verification
The assertions assume that configuration inputs only matter while en is low. They also assume that fault and en are synchronous to clk and held for whole cycles. The stimulus therefore changes the unit, step count, polarity and fault mode only with en low, except in the one test that deliberately disturbs them while enabled. All inputs are driven on the falling clock edge. The prescaler is shortened to 4 clocks per microsecond, so that even the 1 ms unit stays within the run length. The queue assertions assume at most one transition per clock, and this holds because din is sampled once per cycle.

// File: rtl/dly_pkg.sv
package dly_pkg;

  typedef enum logic [1:0] {
    UNIT_1US   = 2'd0,
    UNIT_10US  = 2'd1,
    UNIT_100US = 2'd2,
    UNIT_1MS   = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    FLT_HOLD    = 2'd0,
    FLT_ON      = 2'd1,
    FLT_OFF     = 2'd2,
    FLT_OFF_ALT = 2'd3
  } flt_e;

  // Active output state for a delayed logic level under a polarity select.
  function automatic logic drive_level(input logic lvl, input logic inv);
    return lvl ^ inv;
  endfunction

  // Length of one unit in system clocks.
  function automatic int unsigned unit_len(input unit_e u, input int unsigned cpu);
    int unsigned n;
    n = cpu;
    for (int i = 0; i < 3; i++) if (i < int'(u)) n = n * 10;
    return n;
  endfunction

endpackage

// File: rtl/dly_prescaler.sv
module dly_prescaler #(
  parameter int unsigned CLKS_PER_US = 200
)(
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] tick_vec
);
  localparam int unsigned CW = $clog2(CLKS_PER_US + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

  logic [CW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              base_q <= '0;
    else if (base_q == LAST) base_q <= '0;
    else                     base_q <= base_q + CW'(1);
  end

  assign tick_vec[0] = (base_q == LAST);

  for (genvar g = 1; g < 4; g++) begin : g_decade
    logic [3:0] dec_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                  dec_q <= '0;
      else if (tick_vec[g-1])      dec_q <= (dec_q == 4'd9) ? 4'd0 : dec_q + 4'd1;
    end
    assign tick_vec[g] = tick_vec[g-1] && (dec_q == 4'd9);

    AST_DECADE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_q <= 4'd9); // R1
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_vec[0] |=> !tick_vec[0]); // R1

endmodule

// File: rtl/dly_edge_queue.sv
module dly_edge_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             push_lvl,
  input  logic [CNT_W-1:0] push_cnt,
  input  logic             tick,
  output logic             pop,
  output logic             pop_lvl,
  output logic             overflow
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(DEPTH + 1);

  logic             lvl_q [DEPTH];
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [PW-1:0]    rd_q, wr_q;
  logic [NW-1:0]    num_q;
  logic             full_w, accept_w, drop_w;

  assign pop      = (num_q != '0) && (cnt_q[rd_q] == '0);
  assign pop_lvl  = lvl_q[rd_q];
  assign full_w   = (num_q == NW'(DEPTH));
  assign accept_w = push && (!full_w || pop);
  assign drop_w   = push && full_w && !pop;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_q     <= '0;
      wr_q     <= '0;
      num_q    <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        lvl_q[i] <= 1'b0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (tick && cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - CNT_W'(1);
      if (accept_w) begin
        cnt_q[wr_q] <= push_cnt;
        lvl_q[wr_q] <= push_lvl;
        wr_q        <= wr_q + PW'(1);
      end
      if (pop) rd_q <= rd_q + PW'(1);
      if (accept_w && !pop)      num_q <= num_q + NW'(1);
      else if (!accept_w && pop) num_q <= num_q - NW'(1);
      if (drop_w) overflow <= 1'b1;
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    num_q <= NW'(DEPTH)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr |=> overflow); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pop && !overflow); // R9

endmodule

// File: rtl/dly_out_driver.sv
module dly_out_driver import dly_pkg::*; #(
  parameter int unsigned CLKS_PER_US = 200,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned STEP_W      = 16,
  parameter bit          DIFF        = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              din,
  input  logic [1:0]        unit_sel,
  input  logic [STEP_W-1:0] step_cnt,
  input  logic              invert,
  input  logic              fault,
  input  logic [1:0]        fault_mode,
  output logic              out_se,
  output logic              out_p,
  output logic              out_n,
  output logic              overflow
);
  logic [3:0]        tick_vec;
  logic [1:0]        cfg_unit;
  logic [STEP_W-1:0] cfg_steps;
  logic              cfg_inv;
  logic [1:0]        cfg_fmode;
  logic              din_q, din_qq, lvl_q, p_q;
  logic              zero_steps, edge_w, push_w, pop_w, pop_lvl, unit_tick, act_w;

  dly_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_vec(tick_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_unit  <= '0;
      cfg_steps <= '0;
      cfg_inv   <= 1'b0;
      cfg_fmode <= '0;
    end else if (!en) begin
      cfg_unit  <= unit_sel;
      cfg_steps <= step_cnt;
      cfg_inv   <= invert;
      cfg_fmode <= fault_mode;
    end
  end

  assign zero_steps = (cfg_steps == '0);
  assign edge_w     = en && (din_q != din_qq);
  assign push_w     = edge_w && !zero_steps;
  assign unit_tick  = tick_vec[cfg_unit];

  dly_edge_queue #(.DEPTH(DEPTH), .CNT_W(STEP_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .clr(!en),
    .push(push_w), .push_lvl(din_q), .push_cnt(cfg_steps),
    .tick(unit_tick), .pop(pop_w), .pop_lvl(pop_lvl), .overflow(overflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q  <= 1'b0;
      din_qq <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      din_q  <= din;
      din_qq <= en ? din_q : 1'b0;
      if (!en)            lvl_q <= 1'b0;
      else if (zero_steps) lvl_q <= din_q;
      else if (pop_w)     lvl_q <= pop_lvl;
    end
  end

  always_comb begin
    if (!en) act_w = 1'b0;
    else if (fault) begin
      case (flt_e'(cfg_fmode))
        FLT_HOLD: act_w = p_q;
        FLT_ON:   act_w = 1'b1;
        default:  act_w = 1'b0;
      endcase
    end else act_w = drive_level(lvl_q, cfg_inv);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) p_q <= 1'b0;
    else        p_q <= act_w;
  end

  assign out_se = p_q;
  assign out_p  = p_q;

  if (DIFF) begin : g_diff
    logic n_q;
    always_ff @(posedge clk) begin
      if (!rst_n) n_q <= 1'b1;
      else        n_q <= ~act_w;
    end
    assign out_n = n_q;

    AST_LEGS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
      out_p != out_n); // R4
  end else begin : g_single
    assign out_n = 1'b0;
  end

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_se); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) |-> $stable(cfg_steps) && $stable(cfg_inv)); // R8
  AST_FAULT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    en && fault && cfg_fmode == 2'd1 |=> out_p); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && fault && cfg_fmode == 2'd0 |=> $stable(out_p)); // R7

endmodule

// File: tb/dly_out_driver_tb.sv
module dly_out_driver_tb;
  localparam int unsigned CPU = 4;
  localparam int unsigned SW  = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, din = 1'b0, invert = 1'b0, fault = 1'b0;
  logic [1:0] unit_sel = 2'd0, fault_mode = 2'd0;
  logic [SW-1:0] step_cnt = '0;
  logic out_se, out_p, out_n, overflow;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dly_out_driver #(.CLKS_PER_US(CPU), .DEPTH(4), .STEP_W(SW), .DIFF(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .unit_sel(unit_sel),
    .step_cnt(step_cnt), .invert(invert), .fault(fault), .fault_mode(fault_mode),
    .out_se(out_se), .out_p(out_p), .out_n(out_n), .overflow(overflow)
  );

  // {unit code, invert, steps}
  localparam bit [18:0] VECS [0:5] = '{
    {2'd0, 1'b0, 16'd20},
    {2'd1, 1'b0, 16'd2},
    {2'd0, 1'b1, 16'd5},
    {2'd2, 1'b0, 16'd1},
    {2'd3, 1'b1, 16'd1},
    {2'd0, 1'b0, 16'd0}
  };

  function automatic int unit_clks(input int code);
    int r = CPU;
    for (int k = 0; k < code; k++) r = r * 10;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Negedges until out_p changes; caller drives at a negedge just before.
  task automatic measure(output int n, input int limit);
    logic start;
    start = out_p;
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (out_p != start) break;
    end
  endtask

  task automatic setup(input int u, input int s, input bit inv, input int fm);
    en = 1'b0; din = 1'b0; fault = 1'b0;
    unit_sel = 2'(u); step_cnt = SW'(s); invert = inv; fault_mode = 2'(fm);
    cyc(3);
    en = 1'b1;
    cyc(3);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, w, lo, hi, u, s;
    bit inv;
    cyc(3);
    // R10 reset state
    chk(out_se == 1'b0 && out_p == 1'b0, "R10 out after reset", int'(out_p), 0);
    chk(out_n == 1'b1, "R10 out_n after reset", int'(out_n), 1);
    chk(overflow == 1'b0, "R10 overflow after reset", int'(overflow), 0);
    rst_n = 1'b1;
    cyc(2);

    // Table walk: R1, R2, R3, R4
    foreach (VECS[i]) begin
      u   = int'(VECS[i][18:17]);
      inv = VECS[i][16];
      s   = int'(VECS[i][15:0]);
      if (s == 0) begin lo = 3; hi = 3; end
      else begin lo = (s - 1) * unit_clks(u) + 1; hi = s * unit_clks(u) + 5; end
      setup(u, s, inv, 2);
      chk(out_p == inv, "R3 idle level", int'(out_p), int'(inv));
      din = 1'b1;
      measure(n, hi + 10);
      chk(n >= lo && n <= hi, (s == 0) ? "R2 bypass rise" : "R1 rise delay", n, hi);
      chk(out_p == !inv && out_se == !inv, "R3 polarity high", int'(out_p), int'(!inv));
      chk(out_n == !out_p, "R4 legs", int'(out_n), int'(!out_p));
      din = 1'b0;
      measure(n, hi + 10);
      chk(n >= lo && n <= hi, (s == 0) ? "R2 bypass fall" : "R1 fall delay", n, lo);
      if (s == 20 || (u == 1 && s == 2))
        chk(n - 2 <= 80 + unit_clks(u) && n + unit_clks(u) >= 80, "R1 20us bound", n, 80);
    end

    // R5 short pulse
    setup(0, 10, 1'b0, 2);
    din = 1'b1; cyc(12); din = 1'b0;
    measure(n, 100);
    chk(out_p == 1'b1, "R5 pulse appears", int'(out_p), 1);
    measure(w, 100);
    chk(w >= 12 - 4 && w <= 12 + 4, "R5 pulse width", w, 12);

    // R6 overflow
    setup(0, 50, 1'b0, 2);
    for (int k = 0; k < 4; k++) begin din = ~din; cyc(3); end
    chk(overflow == 1'b0, "R6 four pending no overflow", int'(overflow), 0);
    din = ~din; cyc(3);
    chk(overflow == 1'b1, "R6 fifth pending overflow", int'(overflow), 1);
    cyc(5);
    chk(overflow == 1'b1, "R6 overflow sticky", int'(overflow), 1);
    en = 1'b0; cyc(2);
    chk(overflow == 1'b0, "R6 cleared by disable", int'(overflow), 0);

    // R9 disable forces OFF and drops pending
    setup(0, 20, 1'b1, 2);
    chk(out_p == 1'b1, "R9 enabled inverted idle ON", int'(out_p), 1);
    en = 1'b0; cyc(1);
    chk(out_p == 1'b0 && out_n == 1'b1, "R9 OFF after disable", int'(out_p), 0);
    setup(0, 20, 1'b0, 2);
    din = 1'b1; cyc(5);
    en = 1'b0; din = 1'b0; cyc(3);
    en = 1'b1; cyc(120);
    chk(out_p == 1'b0, "R9 pending edge discarded", int'(out_p), 0);

    // R8 config frozen while enabled
    setup(0, 2, 1'b0, 2);
    step_cnt = SW'(30); invert = 1'b1; unit_sel = 2'd3; cyc(3);
    chk(out_p == 1'b0, "R8 invert change ignored", int'(out_p), 0);
    din = 1'b1;
    measure(n, 400);
    chk(n >= 5 && n <= 13, "R8 steps change ignored", n, 8);

    // R7 fault: force ON ignores invert
    setup(0, 2, 1'b1, 1);
    din = 1'b1; cyc(20);
    chk(out_p == 1'b0, "R7 pre-fault OFF", int'(out_p), 0);
    fault = 1'b1; cyc(1);
    chk(out_p == 1'b1 && out_n == 1'b0, "R7 force ON", int'(out_p), 1);
    fault = 1'b0; cyc(1);
    chk(out_p == 1'b0 && out_n == 1'b1, "R7 resume after ON", int'(out_p), 0);
    // force OFF
    setup(0, 2, 1'b0, 2);
    din = 1'b1; cyc(20);
    fault = 1'b1; cyc(1);
    chk(out_p == 1'b0, "R7 force OFF", int'(out_p), 0);
    fault = 1'b0; cyc(1);
    chk(out_p == 1'b1 && out_n == 1'b0, "R7 resume after OFF", int'(out_p), 1);
    // hold
    setup(0, 2, 1'b0, 0);
    din = 1'b1; cyc(20);
    fault = 1'b1; din = 1'b0; cyc(20);
    chk(out_p == 1'b1, "R7 hold last", int'(out_p), 1);
    fault = 1'b0; cyc(1);
    chk(out_p == 1'b0 && out_n == 1'b1, "R7 resume delayed level", int'(out_p), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule